// File: doc/BRIEF.md
# Line-Delay Video Comb Filter

This block splits a stream of signed composite video samples into a combed luminance stream and a combed chroma stream. Each incoming sample is paired with the sample taken exactly one scan line earlier. Their sum gives luminance. Their difference, with the current sample inverted, gives chroma. Picture content hardly changes from one line to the next, while the colour subcarrier flips phase by half a cycle every line. The sum therefore keeps luminance and removes chroma, and the difference does the opposite.

Samples arrive on a sample strobe at three times the colour subcarrier rate. The line store holds one full line of samples, 683 by default. Both paths are halved so that each output keeps unity gain and the word width of the input. A third output gives vertical detail: a first-order recursive low-pass of the chroma-path result, whose coefficient is chosen at run time as a power-of-two shift. Every output is registered and moves only on a strobe.

Top module: `video_line_comb`

## Requirements
- R1: Once the line store is full, on each strobe `luma_o` becomes floor((x + d) / 2), where x is the current sample and d is the line-delayed sample, both read as two's complement.
- R2: Once the line store is full, on each strobe `chroma_o` becomes floor((d - x) / 2).
- R3: The delayed sample d is exactly the sample accepted `LINE_LEN` strobes earlier. Cycles without a strobe do not count toward this delay.
- R4: For the first `LINE_LEN` strobes after reset, d is taken as zero. In that window `luma_o` is floor(x/2) and `chroma_o` is floor(-x/2).
- R5: Full-scale inputs never wrap. With two samples of the most positive value, `luma_o` equals that value. With two samples of the most negative value, `luma_o` equals that value.
- R6: On each strobe, `detail_o` becomes a + floor((c - a) / 2^k). Here a is its previous value, c is the new `chroma_o` value and k is `coef_sel`. With k = 0, `detail_o` equals `chroma_o`.
- R7: When `sample_en` is low, no output changes and the line position does not advance, whatever `sample_i` holds.
- R8: An active-low asynchronous `rst_n` clears all three outputs, the detail accumulator, the line position and the store-full state.
- R9: Outputs change on the rising clock edge that accepts a strobe. There is one register stage from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample strobe; one sample is accepted per high cycle |
| sample_i | input | SAMPLE_W | Signed composite sample |
| coef_sel | input | COEF_W | Shift coefficient k of the vertical-detail low-pass |
| luma_o | output | SAMPLE_W | Combed luminance, signed |
| chroma_o | output | SAMPLE_W | Combed chroma, signed |
| detail_o | output | SAMPLE_W | Low-passed chroma-path vertical detail, signed |

## Verification
Some properties are checked by assertions on every cycle:
- outputs hold while the strobe is low;
- the line position advances by one and wraps at the end of the line;
- luminance equals half the input while the store is still filling;
- detail equals chroma whenever the shift is zero.

Other behaviour shows only in the bench scenarios, which compare the outputs against a queue-based model on every clock:
- the exact one-line alignment across gaps in the strobe;
- cancellation of a phase-alternating subcarrier and of a flat picture;
- full-scale inputs;
- the low-pass response for several coefficients;
- the restart after a mid-stream reset.

// File: rtl/comb_pkg.sv
package comb_pkg;

  // width of an index able to address n entries (at least one bit)
  function automatic int idx_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/comb_line_store.sv
module comb_line_store #(
  parameter int DEPTH = 683,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] old_data,
  output logic         full_o
);
  localparam int PW = comb_pkg::idx_width(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] pos_q, pos_d;
  logic          full_q, full_d;

  // next-state
  always_comb begin
    pos_d  = pos_q;
    full_d = full_q;
    if (adv) begin
      if (pos_q == LAST) begin
        pos_d  = '0;
        full_d = 1'b1;
      end else begin
        pos_d = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      full_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      full_q <= full_d;
    end
  end

  // storage array: no reset, gated write
  always_ff @(posedge clk) begin
    if (adv) store[pos_q] <= wr_data;
  end

  // read-before-write: the entry about to be overwritten is one line old
  assign old_data = full_q ? store[pos_q] : '0;
  assign full_o   = full_q;

  assert_pos_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pos_q == LAST) |=> (pos_q == '0));
  assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pos_q != LAST) |=> (pos_q == $past(pos_q) + PW'(1)));
  assert_pos_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos_q));
  assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);
endmodule

// File: rtl/comb_halver.sv
module comb_halver #(
  parameter int W = 10
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] old,
  output logic [W-1:0] sum_half,
  output logic [W-1:0] diff_half
);
  logic signed [W:0] cur_x, old_x, sum_w, diff_w;

  always_comb begin
    cur_x     = $signed({cur[W-1], cur});
    old_x     = $signed({old[W-1], old});
    sum_w     = old_x + cur_x;
    diff_w    = old_x - cur_x;
    // dropping the lsb of a two's complement word is a floor halving
    sum_half  = sum_w[W:1];
    diff_half = diff_w[W:1];
  end
endmodule

// File: rtl/comb_detail_lpf.sv
module comb_detail_lpf #(
  parameter int W  = 10,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] shift,
  input  logic [W-1:0]  target,
  output logic [W-1:0]  acc_o
);
  logic [W-1:0]      acc_q, acc_d;
  logic signed [W:0] err, step, sum_w;

  // the step stays between zero and the error, so the result fits in W bits
  always_comb begin
    err   = $signed({target[W-1], target}) - $signed({acc_q[W-1], acc_q});
    step  = err >>> shift;
    sum_w = $signed({acc_q[W-1], acc_q}) + step;
    acc_d = en ? sum_w[W-1:0] : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  assert_lpf_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (sum_w[W] == sum_w[W-1]));
endmodule

// File: rtl/video_line_comb.sv
module video_line_comb #(
  parameter int SAMPLE_W = 10,
  parameter int LINE_LEN = 683,
  parameter int COEF_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [COEF_W-1:0]   coef_sel,
  output logic [SAMPLE_W-1:0] luma_o,
  output logic [SAMPLE_W-1:0] chroma_o,
  output logic [SAMPLE_W-1:0] detail_o
);
  logic [SAMPLE_W-1:0] line_old, luma_nx, chroma_nx;
  logic [SAMPLE_W-1:0] luma_q, luma_d, chroma_q, chroma_d;
  logic                store_full;

  comb_line_store #(.DEPTH(LINE_LEN), .W(SAMPLE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (sample_en),
    .wr_data  (sample_i),
    .old_data (line_old),
    .full_o   (store_full)
  );

  comb_halver #(.W(SAMPLE_W)) u_halver (
    .cur       (sample_i),
    .old       (line_old),
    .sum_half  (luma_nx),
    .diff_half (chroma_nx)
  );

  comb_detail_lpf #(.W(SAMPLE_W), .CW(COEF_W)) u_detail (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (sample_en),
    .shift  (coef_sel),
    .target (chroma_nx),
    .acc_o  (detail_o)
  );

  // next-state
  always_comb begin
    luma_d   = sample_en ? luma_nx   : luma_q;
    chroma_d = sample_en ? chroma_nx : chroma_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_q   <= '0;
      chroma_q <= '0;
    end else begin
      luma_q   <= luma_d;
      chroma_q <= chroma_d;
    end
  end

  assign luma_o   = luma_q;
  assign chroma_o = chroma_q;

  logic [SAMPLE_W-1:0] in_half;
  assign in_half = {sample_i[SAMPLE_W-1], sample_i[SAMPLE_W-1:1]};

  assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(luma_o) && $stable(chroma_o) && $stable(detail_o)));
  assert_fill_luma_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !store_full) |=> (luma_o == $past(in_half)));
  assert_detail_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && coef_sel == '0) |=> (detail_o == chroma_o));
  assert_store_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    store_full |=> store_full);
endmodule

// File: tb/video_line_comb_tb.sv
module video_line_comb_tb;
  localparam int W  = 10;
  localparam int N  = 683;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_en = 1'b0;
  logic [W-1:0]  sample_i = '0;
  logic [CW-1:0] coef_sel = '0;
  logic [W-1:0]  luma_o, chroma_o, detail_o;

  video_line_comb #(.SAMPLE_W(W), .LINE_LEN(N), .COEF_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_i(sample_i),
    .coef_sel(coef_sel), .luma_o(luma_o), .chroma_o(chroma_o), .detail_o(detail_o)
  );

  always #2 clk = ~clk;

  int     errors = 0;
  int     checks = 0;
  bit     done = 0;
  integer hist[$];
  integer exp_l = 0, exp_c = 0, exp_d = 0;

  task automatic chk(input string req, input string what, input integer got, input integer exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "luma",   integer'($signed(luma_o)),   exp_l);
    chk(req, "chroma", integer'($signed(chroma_o)), exp_c);
    chk(req, "detail", integer'($signed(detail_o)), exp_d);
  endtask

  // one clock: drive at the falling edge, model at the rising edge, compare at the next falling edge
  task automatic step(input integer x, input bit e, input integer k, input string req);
    integer d;
    sample_i  = W'(x);
    sample_en = e;
    coef_sel  = CW'(k);
    @(posedge clk);
    if (e) begin
      d = 0;
      if (hist.size() == N) d = hist.pop_front();
      hist.push_back(x);
      exp_l = (x + d) >>> 1;
      exp_c = (d - x) >>> 1;
      exp_d = exp_d + ((exp_c - exp_d) >>> k);
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset(input string req);
    rst_n = 1'b0;
    sample_en = 1'b0;
    hist.delete();
    exp_l = 0; exp_c = 0; exp_d = 0;
    @(negedge clk);
    compare(req);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic integer pic(input integer line, input integer p);
    integer y, c;
    y = (p * 3) % 200 - 50;
    c = (p % 3 == 0) ? 0 : ((p % 3 == 1) ? 104 : -104);
    return (line % 2 == 1) ? y + c : y - c;
  endfunction

  initial begin
    @(negedge clk);
    do_reset("R8");

    // R4 / R9: first line with an empty store
    for (int p = 0; p < N; p++) step(pic(0, p), 1'b1, 0, "R4");
    // R1 R2: alternating-phase subcarrier over a repeated picture
    for (int p = 0; p < N; p++) step(pic(1, p), 1'b1, 0, "R1");
    // R7: strobe gaps with junk on the input, alignment must survive (R3)
    for (int p = 0; p < N; p++) begin
      if (p % 7 == 3) step((p * 37) % 400 - 200, 1'b0, 0, "R7");
      step(pic(2, p), 1'b1, 0, "R2");
    end
    // R3: single impulse then a flat line
    for (int p = 0; p < N; p++) step((p == 100) ? 300 : 0, 1'b1, 2, "R3");
    for (int p = 0; p < N; p++) step(0, 1'b1, 2, "R3");
    // R6: varying shift coefficient on a stepped chroma pattern
    for (int p = 0; p < N; p++) step(((p / 50) % 2 == 0) ? 240 : -240, 1'b1, (p / 120) % 6, "R6");
    // R5: full-scale extremes
    for (int p = 0; p < N; p++) step((p < 300) ? 511 : -512, 1'b1, 1, "R5");
    for (int p = 0; p < N; p++) step((p < 300) ? 511 : -512, 1'b1, 1, "R5");
    // R8: reset in mid-line, then refill from an empty store
    for (int p = 0; p < 50; p++) step(pic(3, p), 1'b1, 3, "R9");
    do_reset("R8");
    for (int p = 0; p < N + 40; p++) step(pic(4, p), 1'b1, 3, "R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule